// File: doc/BRIEF.md
# Stack Pointer Offset Tracker

This block sits in an instruction decode path and removes the serial dependence that implicit stack-pointer updates create between neighbouring operations. It takes a stream of decoded operations and keeps a small signed running offset that stands for stack-pointer changes already implied but not yet applied. Pushes, pops, calls and returns become memory operations with a fixed displacement against that offset, so none of them has to update the stack pointer. Immediate adjustments of the stack pointer are absorbed into the offset where they fit. Memory operands addressed relative to the stack pointer get the offset added to their displacement.

When an operation reads or writes the stack pointer directly, the block first injects one add operation that commits the pending offset to the stack pointer, clears the offset, and then lets the operation through. The same injected add is used whenever a push, pop, call or return would move the offset outside its signed range. Both sides use a valid/ready handshake. An injected add costs one input cycle. A flush discards the pending output and zeroes the offset, because the architectural stack pointer is restored elsewhere.

Input kind codes: 0 plain, 1 push, 2 pop, 3 call, 4 return, 5 stack-pointer add immediate, 6 stack-relative memory operand, 7 explicit stack-pointer use. Output kind codes are the same, with 5 meaning "add the displacement to the stack pointer". The offset is OFFW bits signed, with a default range of -128 to 127. A slot is SLOT bytes, 4 by default.

Top module: `skt_tracker`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the tracked offset is 0.
- R2: An accepted push (kind 1) emits kind 1 with displacement equal to the offset minus SLOT, carries in_tag unchanged, and leaves the offset reduced by SLOT.
- R3: An accepted call (kind 3) follows the same displacement and offset rule as a push, is emitted as kind 3 and carries in_tag.
- R4: An accepted pop (kind 2) emits kind 2 with displacement equal to the current offset, then raises the offset by SLOT.
- R5: An accepted return (kind 4) emits kind 4 with displacement equal to the current offset, then raises the offset by SLOT.
- R6: A stack-pointer add (kind 5) whose sum with the offset fits the offset range produces no output and changes the offset by the immediate. Otherwise it emits kind 5 with displacement offset plus immediate and clears the offset.
- R7: A stack-relative memory operand (kind 6) emits kind 6 with displacement in_disp plus the offset. The offset is unchanged.
- R8: An explicit stack-pointer use (kind 7) with a nonzero offset is preceded by an injected kind 5 beat with displacement equal to the offset and tag 0. The offset is then 0, and the use passes as kind 7 with in_disp unchanged. With a zero offset, no beat is injected.
- R9: A push, call, pop or return whose offset update would leave the signed range first injects a kind 5 beat with the old offset as displacement. The operation is then applied from an offset of 0.
- R10: A flush drops any pending output beat and sets the offset to 0 on the next cycle.
- R11: An output beat stays valid and unchanged while out_ready is 0. Every injected beat holds in_ready low for exactly one cycle for that input. No beat is lost or duplicated.
- R12: A plain operation (kind 0) passes as kind 0 with in_disp and in_tag unchanged, and the offset is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush: clears offset and pending beat |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Input operation accepted this cycle when valid |
| in_kind | input | 3 | Input operation kind code |
| in_disp | input | DISPW | Signed displacement or immediate |
| in_tag | input | TAGW | Operand tag carried through (register id, return address index) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_kind | output | 3 | Output operation kind code |
| out_disp | output | DISPW+1 | Signed adjusted displacement |
| out_tag | output | TAGW | Tag of the output beat, 0 for injected adds |

## Verification
The assertions assume that in_kind, in_disp and in_tag stay stable while in_valid is high and in_ready is low, and that flush and reset are never raised in the middle of a check window they are not meant to cover. The bench drives every input through one stepping task that changes values only at the falling edge. It holds an offered operation until it is accepted. Flush is raised only in a directed sequence, with the input idle. Random immediates are mostly small, so that folding, range overflow and plain forwarding all occur. A few large values force the unfoldable add path.

// File: rtl/skt_pkg.sv
package skt_pkg;

  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_SPADD = 3'd5,
    OP_SPREL = 3'd6,
    OP_SPUSE = 3'd7
  } skt_op_e;

  // true when v is representable as a w-bit two's complement value
  function automatic logic fits_signed(input int v, input int w);
    return (v >= -(1 <<< (w - 1))) && (v < (1 <<< (w - 1)));
  endfunction

endpackage

// File: rtl/skt_decide.sv
module skt_decide
  import skt_pkg::*;
#(
  parameter int OFFW  = 8,
  parameter int DISPW = 10,
  parameter int SLOT  = 4,
  localparam int ODW  = DISPW + 1
) (
  input  skt_op_e                 kind_i,
  input  logic signed [DISPW-1:0] disp_i,
  input  logic signed [OFFW-1:0]  off_i,
  output logic                    sync_o,
  output logic                    emit_o,
  output skt_op_e                 kind_o,
  output logic signed [ODW-1:0]   disp_o,
  output logic signed [OFFW-1:0]  off_n_o
);

  int o, d, dn, up, sm, val, nxt;

  always_comb begin
    o   = int'(off_i);
    d   = int'(disp_i);
    dn  = o - SLOT;
    up  = o + SLOT;
    sm  = o + d;
    sync_o = 1'b0;
    emit_o = 1'b1;
    kind_o = kind_i;
    val    = d;
    nxt    = o;
    unique case (kind_i)
      OP_PUSH, OP_CALL: begin
        if (!fits_signed(dn, OFFW)) sync_o = 1'b1;
        else begin val = dn; nxt = dn; end
      end
      OP_POP, OP_RET: begin
        if (!fits_signed(up, OFFW)) sync_o = 1'b1;
        else begin val = o; nxt = up; end
      end
      OP_SPADD: begin
        if (fits_signed(sm, OFFW)) begin emit_o = 1'b0; nxt = sm; end
        else begin val = sm; nxt = 0; end
      end
      OP_SPREL: val = sm;
      OP_SPUSE: if (o != 0) sync_o = 1'b1;
      default: ;
    endcase
    if (sync_o) begin
      kind_o = OP_SPADD;
      val    = o;
      nxt    = 0;
      emit_o = 1'b1;
    end
    disp_o  = ODW'(val);
    off_n_o = OFFW'(nxt);
  end

endmodule

// File: rtl/skt_outreg.sv
module skt_outreg #(
  parameter int ODW  = 11,
  parameter int TAGW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  load_i,
  input  logic [2:0]            kind_i,
  input  logic signed [ODW-1:0] disp_i,
  input  logic [TAGW-1:0]       tag_i,
  input  logic                  out_ready,
  output logic                  adv_o,
  output logic                  out_valid,
  output logic [2:0]            out_kind,
  output logic signed [ODW-1:0] out_disp,
  output logic [TAGW-1:0]       out_tag
);

  assign adv_o = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_disp  <= '0;
      out_tag   <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (adv_o) begin
      out_valid <= load_i;
      if (load_i) begin
        out_kind <= kind_i;
        out_disp <= disp_i;
        out_tag  <= tag_i;
      end
    end
  end

endmodule

// File: rtl/skt_tracker.sv
module skt_tracker
  import skt_pkg::*;
#(
  parameter int OFFW  = 8,
  parameter int DISPW = 10,
  parameter int TAGW  = 8,
  parameter int SLOT  = 4,
  localparam int ODW  = DISPW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2:0]              in_kind,
  input  logic signed [DISPW-1:0] in_disp,
  input  logic [TAGW-1:0]         in_tag,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [2:0]              out_kind,
  output logic signed [ODW-1:0]   out_disp,
  output logic [TAGW-1:0]         out_tag
);

  logic signed [OFFW-1:0] off_q, off_n;
  logic signed [ODW-1:0]  dec_disp;
  skt_op_e                kind_e, dec_kind;
  logic                   sync_inject, emit, adv, go, accept, fold_event;
  logic [TAGW-1:0]        tag_sel;

  assign kind_e = skt_op_e'(in_kind);

  skt_decide #(.OFFW(OFFW), .DISPW(DISPW), .SLOT(SLOT)) u_decide (
    .kind_i (kind_e),
    .disp_i (in_disp),
    .off_i  (off_q),
    .sync_o (sync_inject),
    .emit_o (emit),
    .kind_o (dec_kind),
    .disp_o (dec_disp),
    .off_n_o(off_n)
  );

  // named events used by the bound checker
  assign go         = in_valid && adv && !flush;
  assign accept     = go && !sync_inject;
  assign fold_event = accept && !emit;
  assign in_ready   = adv && !flush && !sync_inject;
  assign tag_sel    = sync_inject ? '0 : in_tag;

  always_ff @(posedge clk) begin
    if (!rst_n)     off_q <= '0;
    else if (flush) off_q <= '0;
    else if (go)    off_q <= off_n;
  end

  skt_outreg #(.ODW(ODW), .TAGW(TAGW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load_i   (go && emit),
    .kind_i   (dec_kind),
    .disp_i   (dec_disp),
    .tag_i    (tag_sel),
    .out_ready(out_ready),
    .adv_o    (adv),
    .out_valid(out_valid),
    .out_kind (out_kind),
    .out_disp (out_disp),
    .out_tag  (out_tag)
  );

endmodule

// File: rtl/skt_tracker_chk.sv
module skt_tracker_chk #(
  parameter int OFFW = 8,
  parameter int ODW  = 11,
  parameter int SLOT = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [2:0]            in_kind,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [2:0]            out_kind,
  input logic signed [ODW-1:0] out_disp,
  input logic signed [OFFW-1:0] off_q,
  input logic                  sync_inject,
  input logic                  fold_event
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_kind) && $stable(out_disp)); // R11

  AST_SYNC_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sync_inject && in_valid && !flush && (!out_valid || out_ready)
      |=> out_valid && out_kind == 3'd5 && off_q == '0); // R9

  AST_SPUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_kind == 3'd7 |-> off_q == '0); // R8

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && off_q == '0); // R10

  AST_FOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fold_event |=> !out_valid); // R6

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_kind == 3'd1 || in_kind == 3'd3)
      |=> off_q == OFFW'($past(off_q) - OFFW'(SLOT))); // R2

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_kind == 3'd2 || in_kind == 3'd4)
      |=> off_q == OFFW'($past(off_q) + OFFW'(SLOT))); // R4

endmodule

bind skt_tracker skt_tracker_chk #(.OFFW(OFFW), .ODW(ODW), .SLOT(SLOT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_kind    (in_kind),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_kind   (out_kind),
  .out_disp   (out_disp),
  .off_q      (off_q),
  .sync_inject(sync_inject),
  .fold_event (fold_event)
);

// File: tb/skt_tracker_test.sv
module skt_tracker_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, flush, in_valid, in_ready, out_valid, out_ready;
  logic [2:0]        in_kind, out_kind;
  logic signed [9:0] in_disp;
  logic [7:0]        in_tag, out_tag;
  logic signed [10:0] out_disp;

  skt_tracker uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_disp(in_disp), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_disp(out_disp), .out_tag(out_tag)
  );

  int total = 0, bad = 0, cyc = 0, mdl_off = 0, rdy_mode = 0;
  bit acc;
  logic       nx_valid = 1'b0;
  logic [2:0] nx_kind = '0;
  logic [9:0] nx_disp = '0;
  logic [7:0] nx_tag = '0;
  int exp_k[$], exp_d[$], exp_t[$], act_k[$], act_d[$], act_t[$];
  string exp_r[$];

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic chk(bit ok, string req, string what, int a, int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  task automatic want(int k, int d, int t, string r);
    exp_k.push_back(k); exp_d.push_back(d); exp_t.push_back(t); exp_r.push_back(r);
  endtask

  function automatic bit in_range(int v);
    return v >= -128 && v <= 127;
  endfunction

  // reference model, written from the requirements
  task automatic mdl(int k, int d, int t);
    case (k)
      1, 3: begin
        if (!in_range(mdl_off - 4)) begin want(5, mdl_off, 0, "R9"); mdl_off = 0; end
        mdl_off -= 4;
        want(k, mdl_off, t, (k == 1) ? "R2" : "R3");
      end
      2, 4: begin
        if (!in_range(mdl_off + 4)) begin want(5, mdl_off, 0, "R9"); mdl_off = 0; end
        want(k, mdl_off, t, (k == 2) ? "R4" : "R5");
        mdl_off += 4;
      end
      5: begin
        if (in_range(mdl_off + d)) mdl_off += d;
        else begin want(5, mdl_off + d, t, "R6"); mdl_off = 0; end
      end
      6: want(6, d + mdl_off, t, "R7");
      7: begin
        if (mdl_off != 0) begin want(5, mdl_off, 0, "R8"); mdl_off = 0; end
        want(7, d, t, "R8");
      end
      default: want(0, d, t, "R12");
    endcase
  endtask

  task automatic step();
    @(negedge clk);
    in_valid = nx_valid; in_kind = nx_kind; in_disp = nx_disp; in_tag = nx_tag;
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : ($urandom_range(0, 3) != 0);
    #2;
    acc = in_valid && in_ready;
    if (out_valid && out_ready) begin
      act_k.push_back(int'(out_kind)); act_d.push_back(int'(out_disp)); act_t.push_back(int'(out_tag));
    end
    if (acc) mdl(int'(in_kind), int'(in_disp), int'(in_tag));
  endtask

  task automatic send(int k, int d, int t);
    nx_kind = 3'(k); nx_disp = 10'(d); nx_tag = 8'(t); nx_valid = 1'b1;
    do step(); while (!acc);
    nx_valid = 1'b0;
  endtask

  task automatic drain();
    int save = rdy_mode;
    rdy_mode = 0;
    repeat (4) step();
    rdy_mode = save;
  endtask

  task automatic compare_all();
    int n = (act_k.size() < exp_k.size()) ? act_k.size() : exp_k.size();
    chk(act_k.size() == exp_k.size(), "R11", "beat count", act_k.size(), exp_k.size());
    for (int i = 0; i < n; i++) begin
      chk(act_k[i] == exp_k[i], exp_r[i], "kind", act_k[i], exp_k[i]);
      chk(act_d[i] == exp_d[i], exp_r[i], "disp", act_d[i], exp_d[i]);
      chk(act_t[i] == exp_t[i], exp_r[i], "tag", act_t[i], exp_t[i]);
    end
    act_k.delete(); act_d.delete(); act_t.delete();
    exp_k.delete(); exp_d.delete(); exp_t.delete(); exp_r.delete();
  endtask

  initial begin
    int d0, k, d;
    void'($urandom(32'd1234));
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_kind = '0; in_disp = '0;
    in_tag = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R1 R2: first push from a zero offset lands at -4
    send(1, 0, 8'h11);
    drain();
    chk(act_d.size() == 1 && act_d[0] == -4, "R1", "first push disp", act_d.size() ? act_d[0] : 99, -4);
    compare_all();

    // R3 R4 R5 R7 R12: mixed directed sequence
    send(1, 0, 1); send(3, 0, 2); send(6, 12, 3); send(2, 0, 4);
    send(4, 0, 5); send(0, -7, 6); send(2, 0, 7);
    drain(); compare_all();

    // R11: injected beat stalls the input exactly one cycle
    send(1, 0, 9); drain(); compare_all();
    nx_kind = 3'd7; nx_disp = 10'd3; nx_tag = 8'd9; nx_valid = 1'b1;
    step(); chk(acc == 1'b0, "R11", "stall cycle in_ready", acc, 0);
    step(); chk(acc == 1'b1, "R11", "accept after stall", acc, 1);
    nx_valid = 1'b0;
    drain(); compare_all();

    // R11: beat held while out_ready is low
    rdy_mode = 2;
    send(0, 77, 5); step();
    chk(out_valid == 1'b1, "R11", "held valid", out_valid, 1);
    d0 = int'(out_disp);
    repeat (3) step();
    chk(out_valid == 1'b1 && int'(out_disp) == d0, "R11", "held disp", int'(out_disp), d0);
    rdy_mode = 0; drain(); compare_all();

    // R6: folded add emits nothing, then shifts later displacements
    send(5, 20, 0); drain();
    chk(act_k.size() == 0, "R6", "folded add beats", act_k.size(), 0);
    compare_all();
    send(6, 0, 1); drain();
    chk(act_d.size() == 1 && act_d[0] == mdl_off, "R6", "offset after fold", act_d.size() ? act_d[0] : 999, mdl_off);
    compare_all();
    // R6: unfoldable add
    send(5, 300, 2); send(1, 0, 3); send(5, -200, 4); drain(); compare_all();

    // R9: push overflow after 32 pushes from zero
    send(7, 0, 0);
    for (int i = 0; i < 33; i++) send(1, 0, i);
    drain(); compare_all();
    // R9: pop overflow
    send(7, 0, 0); send(5, 124, 0); send(2, 0, 6); send(4, 0, 7);
    drain(); compare_all();

    // R10: flush drops a pending beat and zeroes the offset
    send(1, 0, 1); drain(); compare_all();
    rdy_mode = 2;
    send(1, 0, 3); step();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0; #2;
    chk(out_valid == 1'b0, "R10", "out_valid after flush", out_valid, 0);
    act_k.delete(); act_d.delete(); act_t.delete();
    exp_k.delete(); exp_d.delete(); exp_t.delete(); exp_r.delete();
    mdl_off = 0; rdy_mode = 0;
    send(1, 0, 4); drain();
    chk(act_d.size() == 1 && act_d[0] == -4, "R10", "push after flush", act_d.size() ? act_d[0] : 99, -4);
    compare_all();

    // random mix with random back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 3000; i++) begin
      k = int'($urandom_range(0, 7));
      if (k == 5) d = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 1023)) - 512
                                                  : int'($urandom_range(0, 80)) - 40;
      else d = int'($urandom_range(0, 1023)) - 512;
      send(k, d, int'($urandom_range(0, 255)));
    end
    drain(); compare_all();

    summary();
  end

endmodule